// File: doc/BRIEF.md
# Interrupt and bus-request arbiter

This block sits beside an 8-bit processor core. At each boundary the core reports, it decides whether the core keeps running, hands the bus to an external master, or enters an interrupt. It watches three active-low requests: a bus request, a non-maskable interrupt and a maskable interrupt. It also holds the interrupt enable flag, its saved copy and the current interrupt mode. When it takes an interrupt it delivers either a 16-bit jump target or an opcode byte for the core to execute.

Bus requests are sampled at machine-cycle ends. Interrupts are sampled at instruction ends. The priority order is bus request, then non-maskable interrupt, then maskable interrupt. The non-maskable input is edge sensitive and its request is latched. The maskable input is level sensitive. All outputs are registered and take effect in the cycle after the clock edge that sampled their cause.

The reset pin is active low and synchronous. While it is sampled low, the bus is floated and every control output is idle. The internal state is cleared only after the pin has been held low for a set number of consecutive clocks.

Top module: `irq_bus_arbiter`

## Requirements
- R1: When `rst_n` is sampled low on RST_HOLD consecutive edges (default 3), the enable flag and its saved copy are cleared, the mode becomes 0 and any latched non-maskable request is dropped. A shorter low pulse leaves the enable flag and the mode unchanged.
- R2: In the cycle after any edge that samples `rst_n` low, `bus_float`=1, `busack_n`=1, `take`=0, `ack_m1_n`=1 and `ack_iorq_n`=1.
- R3: `busack_n` goes low and `bus_float` goes high only after an edge where `busreq_n`=0 and `mcyc_end`=1. A low `busreq_n` without `mcyc_end` grants nothing. Once granted, an edge that samples `busreq_n`=1 gives `busack_n`=1 and `bus_float`=0 in the next cycle.
- R4: No interrupt is taken on an edge where the bus is granted or is being granted. Pending requests are kept and are served at the first instruction end after the release.
- R5: A falling edge on `nmi_n` is latched and taken at the next `instr_end`, whatever the enable flag holds. Holding `nmi_n` low afterwards gives no second take.
- R6: A non-maskable take gives `take`=1, `take_nmi`=1, `vec_valid`=1 and `vec`=0x0066. It copies the enable flag into the saved copy and clears the flag. `en_restore` copies the saved copy back into the flag.
- R7: A maskable take happens at `instr_end` only when `int_n`=0 and `int_en`=1. When a non-maskable request is pending at the same edge, it wins.
- R8: A maskable take clears the enable flag and its saved copy. It drives `ack_m1_n` and `ack_iorq_n` low together for exactly that one cycle. A non-maskable take leaves them high.
- R9: In mode 1 a maskable take gives `vec`=0x0038, `vec_valid`=1 and `op_valid`=0.
- R10: In mode 2 a maskable take gives `vec`={`i_reg`, `data_in`}, with `i_reg` in bits 15:8, and `vec_valid`=1.
- R11: In mode 0 a maskable take gives `op_valid`=1 and `opcode`=`data_in`, with `vec_valid`=0.
- R12: `mode_wr` loads `mode_sel` with 0, 1 or 2 as the mode. The value 3 is ignored. `en_set` sets both the flag and its copy, and `en_clr` clears both. Priority is take, then `en_clr`, then `en_set`, then `en_restore`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low, must be held for RST_HOLD clocks |
| int_n | input | 1 | Maskable interrupt request, level, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| busreq_n | input | 1 | External bus request, active low |
| instr_end | input | 1 | Core is at an instruction end |
| mcyc_end | input | 1 | Core is at a machine-cycle end |
| en_set | input | 1 | Set the enable flag and its copy |
| en_clr | input | 1 | Clear the enable flag and its copy |
| en_restore | input | 1 | Copy the saved flag back into the enable flag |
| mode_wr | input | 1 | Load a new interrupt mode |
| mode_sel | input | 2 | New interrupt mode |
| i_reg | input | 8 | Vector page byte |
| data_in | input | 8 | Byte on the data bus |
| busack_n | output | 1 | Bus granted, active low |
| bus_float | output | 1 | Float address, data and strobes |
| take | output | 1 | Interrupt taken, one-cycle pulse |
| take_nmi | output | 1 | The take is non-maskable |
| vec_valid | output | 1 | `vec` holds a jump target |
| vec | output | 16 | Jump target |
| op_valid | output | 1 | `opcode` holds a byte to execute |
| opcode | output | 8 | Opcode to execute |
| ack_m1_n | output | 1 | Acknowledge, M1 part, active low |
| ack_iorq_n | output | 1 | Acknowledge, I/O request part, active low |
| int_en | output | 1 | Enable flag |

## Verification
The hardest case to reach is a non-maskable edge that arrives while the bus is granted. It must stay latched through the grant and be taken only at the first instruction end after the release. The stimulus has to line up the grant, the edge, an ignored instruction end and the release. A directed sequence does exactly that. The random phase then mixes grants, edges and boundaries so that many other overlaps occur, including a take racing a grant on the same edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    IM_OPCODE = 2'd0,
    IM_FIXED  = 2'd1,
    IM_TABLE  = 2'd2
  } irq_mode_e;
endpackage

// File: rtl/irq_rst_hold.sv
// Qualifies the reset pin: rst_full is high on the HOLD-th consecutive low sample and after it.
module irq_rst_hold #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_full
);
  generate
    if (HOLD <= 1) begin : g_direct
      assign rst_full = !rst_n;
    end else begin : g_count
      localparam int CW = $clog2(HOLD);
      localparam logic [CW-1:0] LIM = CW'(HOLD - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst_n)            cnt <= '0;
        else if (cnt != LIM)  cnt <= cnt + 1'b1;
      end
      assign rst_full = !rst_n && (cnt == LIM);
    end
  endgenerate
endmodule

// File: rtl/irq_nmi_latch.sv
// Falling-edge detector with a sticky pending flag for the non-maskable request.
module irq_nmi_latch (
  input  logic clk,
  input  logic nmi_n,
  input  logic clr_all,
  input  logic taken,
  output logic hit
);
  logic prev_q;
  logic pend_q;

  assign hit = pend_q | (prev_q & ~nmi_n);

  always_ff @(posedge clk) begin
    prev_q <= nmi_n;
    if (clr_all || taken) pend_q <= 1'b0;
    else                  pend_q <= hit;
  end
endmodule

// File: rtl/irq_bus_grant.sv
// Bus hand-over: grants at machine-cycle ends, releases as soon as the request drops.
module irq_bus_grant (
  input  logic clk,
  input  logic rst_low,
  input  logic busreq_n,
  input  logic mcyc_end,
  output logic grant,
  output logic grab,
  output logic busack_n,
  output logic bus_float
);
  assign grab = grant ? ~busreq_n : (mcyc_end & ~busreq_n);

  always_ff @(posedge clk) begin
    if (rst_low) begin
      grant     <= 1'b0;
      busack_n  <= 1'b1;
      bus_float <= 1'b1;
    end else begin
      grant     <= grab;
      busack_n  <= ~grab;
      bus_float <= grab;
    end
  end

  assert_grant_on_boundary_R3: assert property (@(posedge clk) disable iff (rst_low)
    (busack_n && !mcyc_end) |=> busack_n);
  assert_release_R3: assert property (@(posedge clk) disable iff (rst_low)
    (!busack_n && busreq_n) |=> (busack_n && !bus_float));
endmodule

// File: rtl/irq_vector_form.sv
// Forms the jump target or flags an opcode fetch, by request kind and mode.
module irq_vector_form
  import irq_arb_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NMI_ADDR   = 'h66,
  parameter int FIXED_ADDR = 'h38
) (
  input  logic              is_nmi,
  input  irq_mode_e         mode,
  input  logic [DW-1:0]     page,
  input  logic [DW-1:0]     data,
  output logic [2*DW-1:0]   vec,
  output logic              vec_ok,
  output logic              op_ok
);
  localparam int VW = 2 * DW;

  always_comb begin
    vec    = {page, data};
    vec_ok = 1'b0;
    op_ok  = 1'b0;
    if (is_nmi) begin
      vec    = VW'(NMI_ADDR);
      vec_ok = 1'b1;
    end else begin
      case (mode)
        IM_FIXED: begin vec = VW'(FIXED_ADDR); vec_ok = 1'b1; end
        IM_TABLE: begin vec = {page, data};    vec_ok = 1'b1; end
        default:  op_ok = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter
  import irq_arb_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RST_HOLD   = 3,
  parameter int NMI_ADDR   = 'h66,
  parameter int FIXED_ADDR = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_n,
  input  logic              nmi_n,
  input  logic              busreq_n,
  input  logic              instr_end,
  input  logic              mcyc_end,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              en_restore,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic [DW-1:0]     i_reg,
  input  logic [DW-1:0]     data_in,
  output logic              busack_n,
  output logic              bus_float,
  output logic              take,
  output logic              take_nmi,
  output logic              vec_valid,
  output logic [2*DW-1:0]   vec,
  output logic              op_valid,
  output logic [DW-1:0]     opcode,
  output logic              ack_m1_n,
  output logic              ack_iorq_n,
  output logic              int_en
);
  localparam int VW = 2 * DW;

  logic            rst_full;
  logic            nmi_hit;
  logic            grant, grab;
  logic            svc_ok, tk_nmi, tk_int;
  logic            ie1, ie2;
  irq_mode_e       mode;
  logic [VW-1:0]   vf;
  logic            vf_ok, vf_op;

  irq_rst_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .rst_full(rst_full)
  );

  irq_nmi_latch u_nmi (
    .clk(clk), .nmi_n(nmi_n), .clr_all(rst_full), .taken(tk_nmi), .hit(nmi_hit)
  );

  irq_bus_grant u_grant (
    .clk(clk), .rst_low(!rst_n), .busreq_n(busreq_n), .mcyc_end(mcyc_end),
    .grant(grant), .grab(grab), .busack_n(busack_n), .bus_float(bus_float)
  );

  irq_vector_form #(.DW(DW), .NMI_ADDR(NMI_ADDR), .FIXED_ADDR(FIXED_ADDR)) u_vec (
    .is_nmi(nmi_hit), .mode(mode), .page(i_reg), .data(data_in),
    .vec(vf), .vec_ok(vf_ok), .op_ok(vf_op)
  );

  // Interrupts are served only with the bus kept: not granted, not being granted now.
  assign svc_ok = rst_n & instr_end & ~grant & ~(mcyc_end & ~busreq_n);
  assign tk_nmi = svc_ok & nmi_hit;
  assign tk_int = svc_ok & ~nmi_hit & ~int_n & ie1;

  always_ff @(posedge clk) begin
    if (rst_full) begin
      ie1  <= 1'b0;
      ie2  <= 1'b0;
      mode <= IM_OPCODE;
    end else if (rst_n) begin
      if (tk_nmi) begin
        ie2 <= ie1;
        ie1 <= 1'b0;
      end else if (tk_int || en_clr) begin
        ie1 <= 1'b0;
        ie2 <= 1'b0;
      end else if (en_set) begin
        ie1 <= 1'b1;
        ie2 <= 1'b1;
      end else if (en_restore) begin
        ie1 <= ie2;
      end
      if (mode_wr && mode_sel != 2'd3) mode <= irq_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take       <= 1'b0;
      take_nmi   <= 1'b0;
      vec_valid  <= 1'b0;
      op_valid   <= 1'b0;
      ack_m1_n   <= 1'b1;
      ack_iorq_n <= 1'b1;
      vec        <= '0;
      opcode     <= '0;
    end else begin
      take       <= tk_nmi | tk_int;
      take_nmi   <= tk_nmi;
      vec_valid  <= (tk_nmi | tk_int) & vf_ok;
      op_valid   <= tk_int & vf_op;
      ack_m1_n   <= ~tk_int;
      ack_iorq_n <= ~tk_int;
      if (tk_nmi || tk_int) begin
        vec    <= vf;
        opcode <= data_in;
      end
    end
  end

  assign int_en = ie1;

  assert_reset_idle_R2: assert property (@(posedge clk)
    !rst_n |=> (bus_float && busack_n && !take && ack_m1_n && ack_iorq_n));
  assert_no_take_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |=> !take);
  assert_nmi_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> (vec == VW'(NMI_ADDR) && vec_valid && ack_m1_n && !op_valid));
  assert_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !(take && !take_nmi));
  assert_int_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_nmi) |-> (!ack_m1_n && !ack_iorq_n && !int_en));
endmodule

// File: tb/irq_bus_arbiter_tb.sv
module irq_bus_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, int_n, nmi_n, busreq_n, instr_end, mcyc_end;
  logic en_set, en_clr, en_restore, mode_wr;
  logic [1:0] mode_sel;
  logic [7:0] i_reg, data_in;
  logic busack_n, bus_float, take, take_nmi, vec_valid, op_valid, ack_m1_n, ack_iorq_n, int_en;
  logic [15:0] vec;
  logic [7:0] opcode;

  irq_bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n), .busreq_n(busreq_n),
    .instr_end(instr_end), .mcyc_end(mcyc_end), .en_set(en_set), .en_clr(en_clr),
    .en_restore(en_restore), .mode_wr(mode_wr), .mode_sel(mode_sel), .i_reg(i_reg),
    .data_in(data_in), .busack_n(busack_n), .bus_float(bus_float), .take(take),
    .take_nmi(take_nmi), .vec_valid(vec_valid), .vec(vec), .op_valid(op_valid),
    .opcode(opcode), .ack_m1_n(ack_m1_n), .ack_iorq_n(ack_iorq_n), .int_en(int_en)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    instr_end = 0; mcyc_end = 0; en_set = 0; en_clr = 0; en_restore = 0; mode_wr = 0;
  endtask

  task automatic full_reset();
    quiet(); rst_n = 0;
    repeat (3) cyc();
    rst_n = 1; cyc();
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_sel = m; mode_wr = 1; cyc(); mode_wr = 0;
  endtask

  task automatic enable();
    en_set = 1; cyc(); en_set = 0;
  endtask

  task automatic int_take(input logic [7:0] pg, input logic [7:0] d);
    i_reg = pg; data_in = d; int_n = 0; instr_end = 1; cyc();
    instr_end = 0; int_n = 1;
  endtask

  // reference model state for the random phase
  bit m_ie1, m_ie2, m_pend, m_prev, m_grant;
  bit [1:0] m_mode;
  bit e_take, e_nmi, e_vv, e_ov, e_ack, e_bn, e_fl;
  bit [15:0] e_vec;
  bit [7:0] e_op;

  task automatic model_edge();
    bit fall, hit, grab, svc, tn, ti;
    fall = m_prev & ~nmi_n;
    hit  = m_pend | fall;
    grab = m_grant ? ~busreq_n : (mcyc_end & ~busreq_n);
    svc  = instr_end & ~m_grant & ~(mcyc_end & ~busreq_n);
    tn   = svc & hit;
    ti   = svc & ~hit & ~int_n & m_ie1;
    e_take = tn | ti; e_nmi = tn;
    e_vv = tn | (ti && m_mode != 2'd0);
    e_ov = ti && m_mode == 2'd0;
    e_ack = ~ti; e_bn = ~grab; e_fl = grab;
    if (tn) e_vec = 16'h0066;
    else if (ti) e_vec = (m_mode == 2'd1) ? 16'h0038 : {i_reg, data_in};
    if (ti) e_op = data_in;
    if (tn) begin m_ie2 = m_ie1; m_ie1 = 0; end
    else if (ti || en_clr) begin m_ie1 = 0; m_ie2 = 0; end
    else if (en_set) begin m_ie1 = 1; m_ie2 = 1; end
    else if (en_restore) m_ie1 = m_ie2;
    if (mode_wr && mode_sel != 2'd3) m_mode = mode_sel;
    m_pend = tn ? 1'b0 : hit;
    m_prev = nmi_n;
    m_grant = grab;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; int_n = 1; nmi_n = 1; busreq_n = 1; mode_sel = 0; i_reg = 0; data_in = 0;
    quiet();
    repeat (3) cyc();
    // R2: outputs idle while reset is low; R1: flag cleared
    chk("R2 float", bus_float, 1); chk("R2 busack", busack_n, 1);
    chk("R2 take", take, 0); chk("R2 ack", {ack_m1_n, ack_iorq_n}, 2'b11);
    chk("R1 int_en", int_en, 0);
    rst_n = 1; cyc();
    chk("R2 float released", bus_float, 0);

    // R11: mode 0 after reset, opcode from the bus
    enable();
    chk("R12 en_set", int_en, 1);
    int_take(8'h00, 8'hC7);
    chk("R11 take", take, 1); chk("R11 op_valid", op_valid, 1);
    chk("R11 opcode", opcode, 8'hC7); chk("R11 vec_valid", vec_valid, 0);
    chk("R8 ack", {ack_m1_n, ack_iorq_n}, 2'b00); chk("R8 int_en", int_en, 0);
    cyc();
    chk("R8 one cycle", {take, ack_m1_n, ack_iorq_n}, 3'b011);

    // R9: mode 1 fixed target; R12: code 3 ignored
    set_mode(2'd1); set_mode(2'd3); enable();
    int_take(8'hAB, 8'hCD);
    chk("R9 vec", vec, 16'h0038); chk("R12 mode 3 ignored", vec_valid, 1);
    chk("R9 op_valid", op_valid, 0);

    // R10: mode 2 target from page and bus byte
    set_mode(2'd2); enable();
    int_take(8'h12, 8'h34);
    chk("R10 vec", vec, 16'h1234); chk("R10 vec_valid", vec_valid, 1);

    // R7: masked level request is not taken
    int_take(8'h12, 8'h34);
    chk("R7 masked", take, 0);

    // R5/R6: edge latched, taken with flag clear, once only
    nmi_n = 0; cyc();
    instr_end = 1; cyc();
    chk("R5 nmi taken", {take, take_nmi}, 2'b11);
    chk("R6 vec", vec, 16'h0066); chk("R8 no ack on nmi", {ack_m1_n, ack_iorq_n}, 2'b11);
    cyc();
    chk("R5 no second take", take, 0);
    instr_end = 0; nmi_n = 1; cyc();

    // R6: save and restore of the flag
    enable();
    nmi_n = 0; instr_end = 1; cyc();
    instr_end = 0;
    chk("R6 flag cleared", int_en, 0);
    en_restore = 1; cyc(); en_restore = 0;
    chk("R6 restore", int_en, 1);
    nmi_n = 1; cyc();

    // R7: simultaneous requests, non-maskable wins
    int_n = 0; nmi_n = 0; instr_end = 1; cyc();
    chk("R7 nmi wins", take_nmi, 1);
    instr_end = 0; int_n = 1; nmi_n = 1; cyc();

    // R3/R4: grant, edge while granted, release, then service
    busreq_n = 0; cyc();
    chk("R3 no grant off boundary", busack_n, 1);
    mcyc_end = 1; cyc(); mcyc_end = 0;
    chk("R3 granted", {busack_n, bus_float}, 2'b01);
    nmi_n = 0; instr_end = 1; cyc();
    chk("R4 no take while granted", take, 0);
    instr_end = 0; busreq_n = 1; cyc();
    chk("R3 released", {busack_n, bus_float}, 2'b10);
    instr_end = 1; cyc(); instr_end = 0;
    chk("R4 pending served", take_nmi, 1);
    nmi_n = 1; cyc();

    // R1: short pulse keeps state, full hold clears it
    set_mode(2'd1); enable();
    rst_n = 0; repeat (2) cyc(); rst_n = 1; cyc();
    chk("R1 short keeps flag", int_en, 1);
    int_take(8'h00, 8'h55);
    chk("R1 short keeps mode", vec, 16'h0038);
    full_reset(); enable();
    int_take(8'h00, 8'h77);
    chk("R1 mode 0 after hold", op_valid, 1);

    // random phase against the model
    full_reset();
    m_ie1 = 0; m_ie2 = 0; m_pend = 0; m_prev = 1; m_grant = 0; m_mode = 0;
    e_vec = 0; e_op = 0;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 800; k++) begin
      instr_end  = ($urandom % 3) == 0;
      mcyc_end   = ($urandom % 2) == 0;
      busreq_n   = ($urandom % 5) != 0;
      int_n      = ($urandom % 2) == 0;
      if (($urandom % 4) == 0) nmi_n = ~nmi_n;
      en_set     = ($urandom % 6) == 0;
      en_clr     = ($urandom % 12) == 0;
      en_restore = ($urandom % 10) == 0;
      mode_wr    = ($urandom % 15) == 0;
      mode_sel   = 2'($urandom);
      i_reg      = 8'($urandom);
      data_in    = 8'($urandom);
      model_edge();
      cyc();
      chk("R5 R7 rnd take", {take, take_nmi}, {e_take, e_nmi});
      chk("R3 rnd bus", {busack_n, bus_float}, {e_bn, e_fl});
      chk("R8 rnd ack", {ack_m1_n, ack_iorq_n}, {e_ack, e_ack});
      chk("R12 rnd flag", int_en, m_ie1);
      chk("R11 rnd kind", {vec_valid, op_valid}, {e_vv, e_ov});
      if (e_vv) chk("R10 rnd vec", vec, e_vec);
      if (e_ov) chk("R11 rnd opcode", opcode, e_op);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule